// File: doc/BRIEF.md
# Sequencer State and Output Register Bank

This block holds the state bits and output bits of a programmable J-K sequencer. An external product-term plane computes J and K excitation for every bit. The bank applies that excitation on the rising clock edge and supplies the control features around the registers. A power-on reset presets every bit to 1. An initialization function drives each bit asynchronously to its own configured value, and a resume rule holds clocking back after initialization ends. A configuration bit splits the bank into two independently clocked halves. The control pin can serve either as initialization or as an active-low output enable. Three diagnostic modes let the output pins show the state register, or let values forced onto the pins load either register.

The pins are modelled as a data output `pin_o` with an enable `pin_en_o` and a separate input `pin_i` that carries the externally forced values. When the enable is low the pins are high-impedance. With the split option off, the second clock is ignored. With the split option on, the first clock drives the lower half of both registers and the second clock drives the upper half. NBITS must be even.

Top module: `seq_reg_bank`

## Requirements
- R1: While `rst_ni` is low, every state and output bit is 1, whatever the init pattern inputs and the control pin say; the first rising edge after release updates normally.
- R2: With `cfg_pin_oe_i`=0 and `ctl_pin_i`=1, each state bit takes `init_st_i` and each output bit takes `init_out_i` at once, without a clock, and clock edges change nothing while the pin stays high.
- R3: After the init pin falls, a clock domain updates only on a rising edge that is preceded by a falling edge of that domain's clock seen after the release; each domain tracks this on its own.
- R4: In run mode, on a rising edge each bit of both registers goes to 1 for J=1,K=0, to 0 for J=0,K=1, inverts for J=1,K=1, and holds for J=0,K=0.
- R5: With `cfg_pin_oe_i`=1, `ctl_pin_i`=1 drives `pin_en_o` low, `ctl_pin_i`=0 enables the pins, and the pin never initializes the registers.
- R6: With `cfg_split_i`=1, `clk_a_i` updates bits [NBITS/2-1:0] of both registers and `clk_b_i` updates the upper bits; with `cfg_split_i`=0, `clk_a_i` updates all bits and `clk_b_i` has no effect.
- R7: In observe mode (`diag_obs_i`), `pin_o` shows the state register, the state register follows J-K, and the output register holds.
- R8: In state-load mode (`diag_ld_st_i`), `pin_en_o` is 0, a rising edge loads `pin_i` into the state register, and the output register holds.
- R9: In output-load mode (`diag_ld_out_i`), `pin_en_o` is 0, a rising edge loads `pin_i` into the output register, and the state register holds.
- R10: When several diagnostic requests are high, state-load wins over output-load, and output-load wins over observe.
- R11: In run mode `pin_o` shows the output register and `state_o` shows the state register; `pin_en_o` is 1 unless disabled by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Primary clock |
| clk_b_i | input | 1 | Second clock, upper half when split |
| rst_ni | input | 1 | Active-low power-on reset, presets all to 1 |
| ctl_pin_i | input | 1 | Shared pin: init (high) or output enable (low) |
| cfg_pin_oe_i | input | 1 | 1: shared pin is output enable; 0: init |
| cfg_split_i | input | 1 | 1: two clock domains |
| init_st_i | input | NBITS | Per-bit init value of state register |
| init_out_i | input | NBITS | Per-bit init value of output register |
| j_st_i | input | NBITS | J excitation, state register |
| k_st_i | input | NBITS | K excitation, state register |
| j_out_i | input | NBITS | J excitation, output register |
| k_out_i | input | NBITS | K excitation, output register |
| diag_obs_i | input | 1 | Observe request |
| diag_ld_st_i | input | 1 | State-load request |
| diag_ld_out_i | input | 1 | Output-load request |
| pin_i | input | NBITS | Values forced onto the pins |
| pin_o | output | NBITS | Pin drive value |
| pin_en_o | output | 1 | Pin driver enable (0 = high-impedance) |
| state_o | output | NBITS | State register feedback to the plane |

## Verification
The J-K update is driven with excitation patterns that set, clear, toggle and hold disjoint groups of bits in one edge, so that a swapped J/K or a missing toggle shows up on specific bits. Init and reset are driven with patterns whose bits differ between the state and output registers. The split option is tested by pulsing each clock alone and checking which half moves. Resume is probed by releasing init while the clock is low, so an update that comes one edge early is visible. The diagnostic modes are requested singly and in combination, so that priority errors and leaks into the register that must hold can be seen.

// File: rtl/seq_bank_pkg.sv
package seq_bank_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_OBS    = 2'd1,
    MODE_LD_OUT = 2'd2,
    MODE_LD_ST  = 2'd3
  } diag_mode_e;

  // state-load > output-load > observe
  function automatic diag_mode_e pick_mode(input logic obs, input logic ld_out,
                                           input logic ld_st);
    if (ld_st)       return MODE_LD_ST;
    else if (ld_out) return MODE_LD_OUT;
    else if (obs)    return MODE_OBS;
    else             return MODE_RUN;
  endfunction
endpackage

// File: rtl/seq_bank_ctl.sv
module seq_bank_ctl import seq_bank_pkg::*; (
  input  logic       ctl_pin_i,
  input  logic       cfg_pin_oe_i,
  input  logic       diag_obs_i,
  input  logic       diag_ld_st_i,
  input  logic       diag_ld_out_i,
  output diag_mode_e mode_o,
  output logic       init_o,
  output logic       drv_en_o
);
  logic load_mode;

  assign mode_o    = pick_mode(diag_obs_i, diag_ld_out_i, diag_ld_st_i);
  assign init_o    = ctl_pin_i & ~cfg_pin_oe_i;
  assign load_mode = (mode_o == MODE_LD_ST) || (mode_o == MODE_LD_OUT);
  assign drv_en_o  = ~load_mode & ~(cfg_pin_oe_i & ctl_pin_i);
endmodule

// File: rtl/seq_bank_arm.sv
module seq_bank_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  output logic armed_o
);
  // cleared by init, re-armed by a falling clock edge once init is gone
  always_ff @(negedge clk_i or negedge rst_ni or posedge init_i) begin
    if (!rst_ni)     armed_o <= 1'b1;
    else if (init_i) armed_o <= 1'b0;
    else             armed_o <= 1'b1;
  end
endmodule

// File: rtl/seq_bank_half.sv
module seq_bank_half import seq_bank_pkg::*; #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  diag_mode_e   mode_i,
  input  logic [W-1:0] init_st_i,
  input  logic [W-1:0] init_out_i,
  input  logic [W-1:0] j_st_i,
  input  logic [W-1:0] k_st_i,
  input  logic [W-1:0] j_out_i,
  input  logic [W-1:0] k_out_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] st_q_o,
  output logic [W-1:0] out_q_o
);
  logic         armed;
  logic [W-1:0] st_jk, out_jk;

  seq_bank_arm i_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .armed_o (armed)
  );

  assign st_jk  = (j_st_i & ~st_q_o) | (~k_st_i & st_q_o);
  assign out_jk = (j_out_i & ~out_q_o) | (~k_out_i & out_q_o);

  always_ff @(posedge clk_i or negedge rst_ni or posedge init_i) begin
    if (!rst_ni)     st_q_o <= '1;
    else if (init_i) st_q_o <= init_st_i;
    else if (armed) begin
      case (mode_i)
        MODE_LD_ST:  st_q_o <= pin_i;
        MODE_LD_OUT: st_q_o <= st_q_o;
        default:     st_q_o <= st_jk;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge init_i) begin
    if (!rst_ni)     out_q_o <= '1;
    else if (init_i) out_q_o <= init_out_i;
    else if (armed) begin
      case (mode_i)
        MODE_LD_OUT: out_q_o <= pin_i;
        MODE_RUN:    out_q_o <= out_jk;
        default:     out_q_o <= out_q_o;
      endcase
    end
  end
endmodule

// File: rtl/seq_reg_bank.sv
module seq_reg_bank import seq_bank_pkg::*; #(
  parameter int NBITS = 8
) (
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             rst_ni,
  input  logic             ctl_pin_i,
  input  logic             cfg_pin_oe_i,
  input  logic             cfg_split_i,
  input  logic [NBITS-1:0] init_st_i,
  input  logic [NBITS-1:0] init_out_i,
  input  logic [NBITS-1:0] j_st_i,
  input  logic [NBITS-1:0] k_st_i,
  input  logic [NBITS-1:0] j_out_i,
  input  logic [NBITS-1:0] k_out_i,
  input  logic             diag_obs_i,
  input  logic             diag_ld_st_i,
  input  logic             diag_ld_out_i,
  input  logic [NBITS-1:0] pin_i,
  output logic [NBITS-1:0] pin_o,
  output logic             pin_en_o,
  output logic [NBITS-1:0] state_o
);
  localparam int NDOM = 2;
  localparam int HALF = NBITS / NDOM;

  diag_mode_e       mode;
  logic             init_act;
  logic [NDOM-1:0]  dom_clk;
  logic [NBITS-1:0] st_q, out_q;

  seq_bank_ctl i_ctl (
    .ctl_pin_i     (ctl_pin_i),
    .cfg_pin_oe_i  (cfg_pin_oe_i),
    .diag_obs_i    (diag_obs_i),
    .diag_ld_st_i  (diag_ld_st_i),
    .diag_ld_out_i (diag_ld_out_i),
    .mode_o        (mode),
    .init_o        (init_act),
    .drv_en_o      (pin_en_o)
  );

  assign dom_clk[0] = clk_a_i;
  assign dom_clk[1] = cfg_split_i ? clk_b_i : clk_a_i;

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    seq_bank_half #(.W(HALF)) i_half (
      .clk_i      (dom_clk[g]),
      .rst_ni     (rst_ni),
      .init_i     (init_act),
      .mode_i     (mode),
      .init_st_i  (init_st_i[g*HALF +: HALF]),
      .init_out_i (init_out_i[g*HALF +: HALF]),
      .j_st_i     (j_st_i[g*HALF +: HALF]),
      .k_st_i     (k_st_i[g*HALF +: HALF]),
      .j_out_i    (j_out_i[g*HALF +: HALF]),
      .k_out_i    (k_out_i[g*HALF +: HALF]),
      .pin_i      (pin_i[g*HALF +: HALF]),
      .st_q_o     (st_q[g*HALF +: HALF]),
      .out_q_o    (out_q[g*HALF +: HALF])
    );
  end

  assign pin_o   = (mode == MODE_OBS) ? st_q : out_q;
  assign state_o = st_q;
endmodule

module seq_bank_chk #(
  parameter int NBITS = 8
) (
  input logic             clk_a_i,
  input logic             rst_ni,
  input logic             init_act,
  input logic             cfg_split_i,
  input logic             diag_obs_i,
  input logic             diag_ld_st_i,
  input logic             diag_ld_out_i,
  input logic [NBITS-1:0] init_st_i,
  input logic [NBITS-1:0] init_out_i,
  input logic [NBITS-1:0] pin_o,
  input logic             pin_en_o,
  input logic [NBITS-1:0] state_o,
  input logic [NBITS-1:0] out_q
);
  a_r1_por_ones: assert property (@(posedge clk_a_i)
    !rst_ni |-> (state_o == '1 && out_q == '1));

  a_r2_init_pattern: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    init_act |-> (state_o == init_st_i && out_q == init_out_i));

  a_r7_obs_shows_state: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (diag_obs_i && !diag_ld_st_i && !diag_ld_out_i) |-> (pin_o == state_o));

  a_r8_ld_st_hiz: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    diag_ld_st_i |-> !pin_en_o);

  a_r8_ld_st_out_holds: assert property (@(posedge clk_a_i)
    disable iff (!rst_ni || init_act)
    (diag_ld_st_i && !cfg_split_i) |=> $stable(out_q));

  a_r9_ld_out_st_holds: assert property (@(posedge clk_a_i)
    disable iff (!rst_ni || init_act)
    (diag_ld_out_i && !diag_ld_st_i && !cfg_split_i) |=> $stable(state_o));
endmodule

bind seq_reg_bank seq_bank_chk #(.NBITS(NBITS)) i_chk (
  .clk_a_i       (clk_a_i),
  .rst_ni        (rst_ni),
  .init_act      (init_act),
  .cfg_split_i   (cfg_split_i),
  .diag_obs_i    (diag_obs_i),
  .diag_ld_st_i  (diag_ld_st_i),
  .diag_ld_out_i (diag_ld_out_i),
  .init_st_i     (init_st_i),
  .init_out_i    (init_out_i),
  .pin_o         (pin_o),
  .pin_en_o      (pin_en_o),
  .state_o       (state_o),
  .out_q         (out_q)
);

// File: tb/test_seq_reg_bank.sv
module test_seq_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic clk_a = 1'b1, clk_b = 1'b1, rst_n = 1'b0;
  logic ctl = 1'b0, cfg_oe = 1'b0, cfg_split = 1'b0;
  logic [NB-1:0] init_st = 8'hA5, init_out = 8'h3C;
  logic [NB-1:0] j_st = '0, k_st = '0, j_out = '0, k_out = '0, pin_in = '0;
  logic obs = 1'b0, ld_st = 1'b0, ld_out = 1'b0;
  logic [NB-1:0] pin_o, state_o;
  logic pin_en;

  int total = 0, bad = 0;
  logic [NB-1:0] m_st, m_out;
  bit arm0, arm1;

  seq_reg_bank #(.NBITS(NB)) i_seq_reg_bank (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n), .ctl_pin_i(ctl),
    .cfg_pin_oe_i(cfg_oe), .cfg_split_i(cfg_split), .init_st_i(init_st),
    .init_out_i(init_out), .j_st_i(j_st), .k_st_i(k_st), .j_out_i(j_out),
    .k_out_i(k_out), .diag_obs_i(obs), .diag_ld_st_i(ld_st),
    .diag_ld_out_i(ld_out), .pin_i(pin_in), .pin_o(pin_o), .pin_en_o(pin_en),
    .state_o(state_o)
  );

  function automatic bit init_on();
    return ctl && !cfg_oe;
  endfunction

  function automatic logic [NB-1:0] jk(input logic [NB-1:0] q, input logic [NB-1:0] j,
                                       input logic [NB-1:0] k);
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++)
      r[b] = (j[b] && !k[b]) ? 1'b1 : (!j[b] && k[b]) ? 1'b0 :
             (j[b] && k[b]) ? !q[b] : q[b];
    return r;
  endfunction

  task automatic check(input string tag);
    bit en_x;
    logic [NB-1:0] pin_x;
    en_x  = !(ld_st || ld_out) && !(cfg_oe && ctl);
    pin_x = (obs && !ld_st && !ld_out) ? m_st : m_out;
    total++;
    if (state_o !== m_st) begin
      bad++;
      $display("FAIL %s state actual=%h expected=%h", tag, state_o, m_st);
    end
    total++;
    if (pin_en !== en_x) begin
      bad++;
      $display("FAIL %s pin_en actual=%b expected=%b", tag, pin_en, en_x);
    end
    if (en_x) begin
      total++;
      if (pin_o !== pin_x) begin
        bad++;
        $display("FAIL %s pin actual=%h expected=%h", tag, pin_o, pin_x);
      end
    end
  endtask

  task automatic fall(input bit a, input bit b);
    if (a) clk_a = 1'b0;
    if (b) clk_b = 1'b0;
    if (!init_on()) begin
      if (a) arm0 = 1;
      if (cfg_split ? b : a) arm1 = 1;
    end
    #(CLK_PERIOD/2);
  endtask

  task automatic rise(input bit a, input bit b, input string tag);
    logic [NB-1:0] ns, no, msk;
    clk_a = 1'b1;
    clk_b = 1'b1;
    if (!init_on()) begin
      if (ld_st)                 ns = pin_in;
      else if (ld_out)           ns = m_st;
      else                       ns = jk(m_st, j_st, k_st);
      if (ld_st)                 no = m_out;
      else if (ld_out)           no = pin_in;
      else if (obs)              no = m_out;
      else                       no = jk(m_out, j_out, k_out);
      msk = '0;
      if (a && arm0) msk[NB/2-1:0] = '1;
      if ((cfg_split ? b : a) && arm1) msk[NB-1:NB/2] = '1;
      m_st  = (ns & msk) | (m_st & ~msk);
      m_out = (no & msk) | (m_out & ~msk);
    end
    #2;
    check(tag);
    #(CLK_PERIOD/2 - 2);
  endtask

  task automatic tick(input bit a, input bit b, input string tag);
    fall(a, b);
    rise(a, b, tag);
  endtask

  task automatic set_jk(input logic [NB-1:0] js, input logic [NB-1:0] ks,
                        input logic [NB-1:0] jo, input logic [NB-1:0] ko);
    j_st = js; k_st = ks; j_out = jo; k_out = ko;
  endtask

  task automatic set_ctl(input logic v, input string tag);
    ctl = v;
    if (init_on()) begin
      m_st = init_st; m_out = init_out; arm0 = 0; arm1 = 0;
    end
    #2;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_st = '1; m_out = '1; arm0 = 1; arm1 = 1;
    ctl = 1'b1;                       // init request during reset is overridden
    #3;
    check("R1 reset with init high");
    ctl = 1'b0;
    #2;
    check("R1 reset all ones");
    tick(1, 0, "R1 clock during reset");
    // Expected model stays at all ones: reset holds the flops
    m_st = '1; m_out = '1;
    rst_n = 1'b1;
    #3;

    // R4 / R11 J-K behaviour
    set_jk(8'b0011_0000, 8'b0000_1100, 8'b1010_0000, 8'b0000_0101);
    tick(1, 0, "R4 set/clear groups");
    set_jk(8'b1100_0011, 8'b1100_0011, 8'b1111_0000, 8'b1111_0000);
    tick(1, 0, "R4 toggle");
    set_jk(8'h00, 8'h00, 8'h00, 8'h00);
    tick(1, 0, "R4 hold");
    set_jk(8'hF0, 8'h0F, 8'h0F, 8'hF0);
    tick(1, 0, "R11 run mode pins");
    tick(1, 1, "R6 clk_b ignored unsplit");
    set_jk(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    fall(0, 1);
    rise(0, 1, "R6 clk_b alone unsplit");

    // R2 init
    set_ctl(1'b1, "R2 async init");
    tick(1, 0, "R2 clock ignored during init");
    // R3 resume: release while clock low
    fall(1, 0);
    set_ctl(1'b0, "R3 release");
    rise(1, 0, "R3 no update without fall");
    tick(1, 0, "R3 update after fall");

    // R6 split
    cfg_split = 1'b1;
    set_jk(8'hFF, 8'h00, 8'h00, 8'hFF);
    tick(1, 0, "R6 clk_a lower half");
    tick(0, 1, "R6 clk_b upper half");
    set_jk(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    set_ctl(1'b1, "R2 init split");
    set_ctl(1'b0, "R2 init release split");
    fall(1, 0);
    rise(1, 0, "R3 domain a armed");
    rise(0, 1, "R3 domain b not armed");
    tick(0, 1, "R3 domain b after fall");
    cfg_split = 1'b0;

    // R7 observe
    obs = 1'b1;
    set_jk(8'h0F, 8'hF0, 8'hFF, 8'h00);
    #2; check("R7 observe shows state");
    tick(1, 0, "R7 observe update");
    tick(1, 0, "R7 observe output holds");
    // R8 state load
    obs = 1'b0; ld_st = 1'b1; pin_in = 8'h69;
    tick(1, 0, "R8 state load");
    pin_in = 8'h96;
    tick(1, 0, "R8 state load again");
    // R9 output load
    ld_st = 1'b0; ld_out = 1'b1; pin_in = 8'h5A;
    tick(1, 0, "R9 output load");
    ld_out = 1'b0; #2; check("R9 output reg visible");
    // R10 priority
    obs = 1'b1; ld_out = 1'b1; ld_st = 1'b1; pin_in = 8'hC3;
    tick(1, 0, "R10 state-load wins");
    ld_st = 1'b0; pin_in = 8'h3E;
    tick(1, 0, "R10 output-load over observe");
    ld_out = 1'b0;
    #2; check("R10 observe alone");
    obs = 1'b0;

    // R5 output enable option
    cfg_oe = 1'b1;
    set_ctl(1'b1, "R5 oe deasserted hi-z no init");
    tick(1, 0, "R5 clocking with oe high");
    set_ctl(1'b0, "R5 oe asserted");
    set_jk(8'h00, 8'hFF, 8'hFF, 8'h00);
    tick(1, 0, "R5 run after oe");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule